// File: doc/BRIEF.md
# SPI Serial Clock Rate Divider

This block sets the serial clock rate of an SPI master. It divides the module clock by a factor chosen with two 3-bit fields. The prescale field `presel_i` (value P) gives a linear factor of P+1. The rate field `sel_i` (value S) gives a binary factor of 2^(S+1). The full SCK period is therefore (P+1)·2^(S+1) module clocks, which runs from 2 up to 2048. Because one factor is linear, rates that are not a power of two are available, for example divide by 6 or divide by 10.

The hardware is a linear prescale counter feeding a binary counter. The block emits a one-cycle pulse on `tick_o` at every SCK half-period boundary, that is, every H = (P+1)·2^S module clocks. It also drives `sck_ref_o`, a reference level that toggles on every pulse and so runs at the SCK rate. When `en_i` is low, both counters are held at zero. A change to either field while the block is enabled restarts the count. The shift logic that consumes the pulses is outside this block.

Top module: `spi_baud_div`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `tick_o` and `sck_ref_o` are 0.
- R2: With P=0 and S=0, the divisor is 2 and `tick_o` is high in every cycle while enabled.
- R3: With P=0, every increment of S doubles the pulse spacing. S=1 gives a spacing of 2 (divide by 4), S=2 gives 4 (divide by 8), and S=7 gives 128.
- R4: The field P multiplies the spacing by P+1. P=1,S=0 gives 2; P=2,S=0 gives 3 (divide by 6); P=4,S=0 gives 5 (divide by 10); P=4,S=1 gives 10.
- R5: With P=7 and S=7, the pulse spacing is 1024 clocks (divide by 2048).
- R6: Each `tick_o` pulse lasts exactly one cycle whenever the spacing H is greater than 1.
- R7: If `en_i` rises in cycle c with the fields already stable, the first pulse is seen in cycle c+H. Later pulses follow every H cycles.
- R8: If either field changes while enabled in cycle c, no pulse appears in cycle c+1. Pulses then appear in cycles c+1+k·H' for k ≥ 1, where H' is the spacing of the new fields.
- R9: While `en_i` is low, `tick_o` stays 0. From the cycle after `en_i` is seen low, `sck_ref_o` is 0.
- R10: `sck_ref_o` toggles in exactly the cycles in which `tick_o` is high, and keeps its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Module clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Divider enable; low holds both counters at zero |
| presel_i | input | 3 | Linear prescale field P, factor P+1 |
| sel_i | input | 3 | Binary rate field S, factor 2^(S+1) |
| tick_o | output | 1 | One-cycle pulse at each SCK half-period boundary |
| sck_ref_o | output | 1 | Level that toggles on every pulse |

## Verification
The properties that check field changes compare the present fields with the previous cycle's fields. They therefore assume the fields are driven synchronously and are settled before each clock edge. The stimulus changes fields and enable only on the falling clock edge. Before each enabled run, it sets the fields one cycle ahead of raising `en_i`, so that the run starts as a plain enable and not as a field change. Field changes made while enabled are issued on purpose, as separate runs, to exercise the restart rule.

// File: rtl/spi_baud_pkg.sv
package spi_baud_pkg;
  localparam int unsigned PRE_W_DEF = 3;
  localparam int unsigned SEL_W_DEF = 3;
endpackage

// File: rtl/spi_baud_prescale.sv
module spi_baud_prescale #(
  parameter int unsigned PRE_W = spi_baud_pkg::PRE_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic [PRE_W-1:0] limit_i,
  output logic             tc_o
);
  logic [PRE_W-1:0] cnt_q;

  assign tc_o = (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (tc_o)  cnt_q <= '0;
    else            cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_baud_binstage.sv
module spi_baud_binstage #(
  parameter int unsigned SEL_W = spi_baud_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tc_o
);
  localparam int unsigned BIN_W = (1 << SEL_W) - 1;

  logic [BIN_W-1:0] cnt_q;
  logic [BIN_W-1:0] mask;

  // terminal count is 2^sel - 1
  always_comb begin
    mask = '0;
    for (int i = 0; i < BIN_W; i++) mask[i] = (i < int'(sel_i));
  end

  assign tc_o = step_i && (cnt_q == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (tc_o)   cnt_q <= '0;
    else if (step_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_baud_div.sv
module spi_baud_div #(
  parameter int unsigned PRE_W = spi_baud_pkg::PRE_W_DEF,
  parameter int unsigned SEL_W = spi_baud_pkg::SEL_W_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [PRE_W-1:0] presel_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o,
  output logic             sck_ref_o
);
  localparam int unsigned CFG_W = PRE_W + SEL_W;

  logic [CFG_W-1:0] cfg_q;
  logic             cfg_chg;
  logic             clr;
  logic             pre_tc;
  logic             bin_tc;
  logic             tick_d;
  logic             tick_q;
  logic             ref_q;

  assign cfg_chg = (cfg_q != {presel_i, sel_i});
  assign clr     = !en_i || cfg_chg;
  assign tick_d  = en_i && !cfg_chg && bin_tc;

  spi_baud_prescale #(.PRE_W(PRE_W)) i_pre (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr),
    .limit_i (presel_i),
    .tc_o    (pre_tc)
  );

  spi_baud_binstage #(.SEL_W(SEL_W)) i_bin (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr),
    .step_i (pre_tc),
    .sel_i  (sel_i),
    .tc_o   (bin_tc)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= '0;
      tick_q <= 1'b0;
      ref_q  <= 1'b0;
    end else begin
      cfg_q  <= {presel_i, sel_i};
      tick_q <= tick_d;
      if (!en_i)       ref_q <= 1'b0;
      else if (tick_d) ref_q <= ~ref_q;
    end
  end

  assign tick_o    = tick_q;
  assign sck_ref_o = ref_q;
endmodule

// File: rtl/spi_baud_div_chk.sv
module spi_baud_div_chk #(
  parameter int unsigned PRE_W = 3,
  parameter int unsigned SEL_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [PRE_W-1:0] presel_i,
  input logic [SEL_W-1:0] sel_i,
  input logic             tick_o,
  input logic             sck_ref_o
);
  // R9
  idle_no_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !tick_o);

  // R9
  idle_ref_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !sck_ref_o);

  // R8
  restart_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && $past(en_i) && ({presel_i, sel_i} != $past({presel_i, sel_i}))) |=> !tick_o);

  // R6
  single_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && en_i && ({presel_i, sel_i} != '0)) |=> !tick_o);

  // R10
  ref_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |-> (sck_ref_o != $past(sck_ref_o)));

  // R10
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_o && $past(en_i)) |-> $stable(sck_ref_o));
endmodule

bind spi_baud_div spi_baud_div_chk #(.PRE_W(PRE_W), .SEL_W(SEL_W)) i_chk (.*);

// File: tb/test_spi_baud_div.sv
module test_spi_baud_div;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       en_i = 1'b0;
  logic [2:0] presel_i = '0;
  logic [2:0] sel_i = '0;
  logic       tick_o;
  logic       sck_ref_o;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  int    clr_at = -1;
  bit    mon_on = 1'b0;
  bit    ref_model = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";
  int    exp_q[$];

  spi_baud_div i_spi_baud_div (.*);

  always #5 clk_i = ~clk_i;
  always @(posedge clk_i) cyc <= cyc + 1;

  // monitor: pop expected pulses, check level reference
  always @(negedge clk_i) begin
    if (mon_on) begin
      while (exp_q.size() > 0 && exp_q[0] < cyc) begin
        checks++; errors++;
        $display("FAIL %s missed pulse: actual none expected cycle %0d", cur_req, exp_q[0]);
        void'(exp_q.pop_front());
      end
      if (cyc == clr_at) ref_model = 1'b0;
      if (tick_o) begin
        checks++;
        if (exp_q.size() > 0 && exp_q[0] == cyc) begin
          void'(exp_q.pop_front());
          ref_model = ~ref_model;
        end else begin
          errors++; // R6 extra pulse lands here
          $display("FAIL %s/R6 stray pulse: actual tick at %0d expected %0d", cur_req, cyc,
                   (exp_q.size() > 0) ? exp_q[0] : -1);
        end
      end
      checks++;
      if (sck_ref_o !== ref_model) begin
        errors++;
        $display("FAIL R10 sck_ref at %0d: actual %0b expected %0b", cyc, sck_ref_o, ref_model);
      end
    end
  end

  function automatic int half_of(int p, int s);
    return (p + 1) * (1 << s);
  endfunction

  task automatic push_seg(int start, int h, int last);
    for (int k = start + h; k <= last; k += h) exp_q.push_back(k);
  endtask

  task automatic drain_chk(string req);
    @(negedge clk_i);
    @(negedge clk_i);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL %s pending pulses: actual %0d expected 0", req, exp_q.size());
      exp_q.delete();
    end
  endtask

  task automatic run(int p, int s, int len, string req);
    int c0;
    cur_req = req;
    presel_i = 3'(p); sel_i = 3'(s);
    @(negedge clk_i);
    en_i = 1'b1;
    c0 = cyc;
    push_seg(c0, half_of(p, s), c0 + len);
    repeat (len) @(negedge clk_i);
    en_i = 1'b0;
    clr_at = cyc + 1;
    drain_chk(req);
  endtask

  task automatic run_chg(int p1, int s1, int l1, int p2, int s2, int l2);
    int c0;
    int c1;
    cur_req = "R8";
    presel_i = 3'(p1); sel_i = 3'(s1);
    @(negedge clk_i);
    en_i = 1'b1;
    c0 = cyc;
    push_seg(c0, half_of(p1, s1), c0 + l1);
    repeat (l1) @(negedge clk_i);
    c1 = cyc;
    presel_i = 3'(p2); sel_i = 3'(s2);
    push_seg(c1 + 1, half_of(p2, s2), c1 + l2);
    repeat (l2) @(negedge clk_i);
    en_i = 1'b0;
    clr_at = cyc + 1;
    drain_chk("R8");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    checks++; // R1
    if (tick_o !== 1'b0 || sck_ref_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 in reset: actual %0b%0b expected 00", tick_o, sck_ref_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);
    checks++; // R1
    if (tick_o !== 1'b0 || sck_ref_o !== 1'b0) begin
      errors++;
      $display("FAIL R1 after reset: actual %0b%0b expected 00", tick_o, sck_ref_o);
    end
    mon_on = 1'b1;

    run(0, 0, 20, "R2");
    run(0, 1, 40, "R3");
    run(0, 2, 64, "R3");
    run(0, 7, 600, "R3");
    run(1, 0, 20, "R4");
    run(2, 0, 30, "R4");
    run(4, 0, 50, "R4");
    run(4, 1, 60, "R4");
    run(3, 2, 37, "R7");
    run(7, 7, 4200, "R5");
    run_chg(2, 1, 17, 0, 2, 50);
    run_chg(3, 2, 10, 0, 0, 10);
    run_chg(0, 0, 5, 5, 1, 40);

    // R9: fields move while disabled, nothing may come out
    cur_req = "R9";
    for (int i = 0; i < 24; i++) begin
      presel_i = 3'(i); sel_i = 3'(i >> 2);
      @(negedge clk_i);
      checks++;
      if (tick_o !== 1'b0 || sck_ref_o !== 1'b0) begin
        errors++;
        $display("FAIL R9 idle: actual %0b%0b expected 00", tick_o, sck_ref_o);
      end
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule